// File: doc/BRIEF.md
# Register Producer-Tag Rename Table

This block sits beside the reservation stations of an out-of-order floating-point unit. For every architectural register it keeps either a committed value or the nonzero tag of the reservation station that will produce the next value. When an instruction issues, the table gives each source register's value or pending tag. It records the issuing station's tag against the destination register, replacing any older pending tag for that register.

The block watches the shared tagged result bus. A broadcast is written into a register only if the broadcast tag equals the tag that register is waiting on. A result from a producer that was later superseded therefore never reaches the register file. That result still reaches any station that captured the old tag. Write-after-write and write-after-read ordering problems disappear without stalls.

Each register slot is a two-state machine. In `ST_READY` the tag is 0 and the value is valid. In `ST_PENDING` the tag names the producer. The transitions are as follows:
- `ISSUE` (issue to this register) moves `ST_READY` to `ST_PENDING`.
- `RETAG` (a further issue while pending) keeps the slot in `ST_PENDING` with the new tag.
- `RESOLVE` (a broadcast with the matching tag and no same-cycle issue) returns the slot to `ST_READY`.
- `HOLD` covers every other cycle.

Top module: `rrs_rename_table`

## Requirements
- R1: Each read port is combinational. For the register it selects it returns ready=1, tag=0 and the stored value when that register has no pending producer. Otherwise it returns ready=0 and the pending tag. A same-cycle issue is not visible on the read ports until the next cycle.
- R2: An issue with a valid destination sets that register's tag to the issue tag on the next clock edge. This happens even when an older write to the register is still pending.
- R3: A valid broadcast whose tag equals a register's current pending tag writes the broadcast data into that register on the next edge and clears its tag to 0 (ready).
- R4: A valid broadcast whose tag differs from a register's pending tag leaves that register's tag and value unchanged. A result from a superseded producer is dropped this way.
- R5: When an issue and a matching broadcast target the same register in one cycle, the register ends with the new issue tag and stays pending.
- R6: A read of a register that a same-cycle valid broadcast matches returns ready=1, tag=0 and the broadcast data.
- R7: Reset clears every tag to 0 and every value to 0.
- R8: Tag 0 means "ready". Issue and broadcast tags lie in 1 to 2^TAG_W-1. A broadcast with its valid low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | IDX_W | Register selected by read port A |
| rd_a_value | output | DATA_W | Value seen on port A |
| rd_a_tag | output | TAG_W | Pending producer tag on port A (0 when ready) |
| rd_a_ready | output | 1 | Port A value is valid |
| rd_b_idx | input | IDX_W | Register selected by read port B |
| rd_b_value | output | DATA_W | Value seen on port B |
| rd_b_tag | output | TAG_W | Pending producer tag on port B (0 when ready) |
| rd_b_ready | output | 1 | Port B value is valid |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | IDX_W | Destination register of the issuing instruction |
| iss_tag | input | TAG_W | Producer tag assigned to the destination |
| bc_valid | input | 1 | Result bus carries a result this cycle |
| bc_tag | input | TAG_W | Tag of the producing station |
| bc_data | input | DATA_W | Result value |

## Verification
The assertions assume that an issue never carries tag 0 and that a valid broadcast never carries tag 0. Tag 0 is reserved for "ready", and the slot state and tag agreement depends on that. The stimulus draws every issue and broadcast tag from 1 to 15. Broadcast tags are mostly taken from a register that is currently pending, so that matches, bypasses and superseded results all occur often. Directed sequences add the retag-then-stale-result case and the same-cycle issue-and-resolve case.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic {
        ST_READY   = 1'b0,
        ST_PENDING = 1'b1
    } slot_state_e;
endpackage

// File: rtl/rrs_slot.sv
module rrs_slot
    import rrs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_hit,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic [DATA_W-1:0] slot_value,
    output logic [TAG_W-1:0]  slot_tag,
    output logic              slot_match
);
    slot_state_e       state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] value_q;

    assign slot_match = (state_q == ST_PENDING) && bc_valid && (bc_tag == tag_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (iss_hit) state_d = ST_PENDING;          // ISSUE
            end
            ST_PENDING: begin
                if (iss_hit)         state_d = ST_PENDING;  // RETAG
                else if (slot_match) state_d = ST_READY;    // RESOLVE
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            if (iss_hit)         tag_q <= iss_tag;
            else if (slot_match) tag_q <= '0;
            if (slot_match)      value_q <= bc_data;
        end
    end

    assign slot_value = value_q;
    assign slot_tag   = tag_q;

    AST_STATE_AGREES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING) == (tag_q != '0)); // R8
    AST_RESOLVE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_match && !iss_hit) |=> (tag_q == '0) && (value_q == $past(bc_data))); // R3
    AST_ISSUE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_hit |=> (tag_q == $past(iss_tag)) && (state_q == ST_PENDING)); // R5
    AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_hit && !slot_match) |=> $stable(tag_q) && $stable(value_q)); // R4
endmodule

// File: rtl/rrs_rd_port.sv
module rrs_rd_port #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] slot_value [NREG],
    input  logic [TAG_W-1:0]  slot_tag   [NREG],
    input  logic [NREG-1:0]   slot_match,
    input  logic [DATA_W-1:0] bc_data,
    output logic [DATA_W-1:0] rd_value,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_ready
);
    always_comb begin
        if (slot_match[rd_idx]) begin
            rd_value = bc_data;
            rd_tag   = '0;
            rd_ready = 1'b1;
        end else begin
            rd_value = slot_value[rd_idx];
            rd_tag   = slot_tag[rd_idx];
            rd_ready = (slot_tag[rd_idx] == '0);
        end
    end
endmodule

// File: rtl/rrs_rename_table.sv
module rrs_rename_table #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_value,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic              rd_a_ready,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_value,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic              rd_b_ready,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data
);
    logic [DATA_W-1:0] slot_value [NREG];
    logic [TAG_W-1:0]  slot_tag   [NREG];
    logic [NREG-1:0]   slot_match;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
        logic hit;
        assign hit = iss_valid && (iss_dst == IDX_W'(gi));
        rrs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .iss_hit    (hit),
            .iss_tag    (iss_tag),
            .bc_valid   (bc_valid),
            .bc_tag     (bc_tag),
            .bc_data    (bc_data),
            .slot_value (slot_value[gi]),
            .slot_tag   (slot_tag[gi]),
            .slot_match (slot_match[gi])
        );
    end

    rrs_rd_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) port_a_i (
        .rd_idx     (rd_a_idx),
        .slot_value (slot_value),
        .slot_tag   (slot_tag),
        .slot_match (slot_match),
        .bc_data    (bc_data),
        .rd_value   (rd_a_value),
        .rd_tag     (rd_a_tag),
        .rd_ready   (rd_a_ready)
    );

    rrs_rd_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) port_b_i (
        .rd_idx     (rd_b_idx),
        .slot_value (slot_value),
        .slot_tag   (slot_tag),
        .slot_match (slot_match),
        .bc_data    (bc_data),
        .rd_value   (rd_b_value),
        .rd_tag     (rd_b_tag),
        .rd_ready   (rd_b_ready)
    );

    AST_ISSUE_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_tag != '0)); // R8
    AST_BC_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (bc_tag != '0)); // R8
    AST_ISSUE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> (slot_tag[$past(iss_dst)] == $past(iss_tag))); // R2
    AST_READ_BYPASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && slot_tag[rd_a_idx] != '0 && slot_tag[rd_a_idx] == bc_tag)
        |-> (rd_a_ready && rd_a_value == bc_data && rd_a_tag == '0)); // R6
    AST_READ_PENDING_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_valid && slot_tag[rd_b_idx] != '0) |-> (!rd_b_ready && rd_b_tag == slot_tag[rd_b_idx])); // R1
endmodule

// File: tb/rrs_rename_table_tb.sv
module rrs_rename_table_tb_top;
    localparam int NREG   = 16;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;
    localparam int IDX_W  = $clog2(NREG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  rd_a_idx = '0, rd_b_idx = '0;
    logic [DATA_W-1:0] rd_a_value, rd_b_value;
    logic [TAG_W-1:0]  rd_a_tag, rd_b_tag;
    logic              rd_a_ready, rd_b_ready;
    logic              iss_valid = 1'b0;
    logic [IDX_W-1:0]  iss_dst = '0;
    logic [TAG_W-1:0]  iss_tag = '0;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_data = '0;

    int checks = 0;
    int errors = 0;
    int ref_val [NREG];
    int ref_tag [NREG];

    always #10 clk = ~clk;

    rrs_rename_table #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_value(rd_a_value), .rd_a_tag(rd_a_tag), .rd_a_ready(rd_a_ready),
        .rd_b_idx(rd_b_idx), .rd_b_value(rd_b_value), .rd_b_tag(rd_b_tag), .rd_b_ready(rd_b_ready),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_hit(int i);
        return bc_valid && ref_tag[i] != 0 && int'(bc_tag) == ref_tag[i];
    endfunction

    task automatic cmp_port(string lab, int idx, logic [DATA_W-1:0] v, logic [TAG_W-1:0] t, logic r);
        string req;
        int    et;
        int    ev;
        if (ref_hit(idx)) begin
            req = "R6"; et = 0; ev = int'(bc_data);
        end else begin
            req = "R1"; et = ref_tag[idx]; ev = ref_val[idx];
        end
        if (lab != "") req = lab;
        check(req, "ready", longint'(r), longint'(et == 0));
        check(req, "tag", longint'(t), longint'(et));
        if (et == 0) check(req, "value", longint'(v), longint'(unsigned'(ev)));
    endtask

    // compare the read ports against the model, then advance one clock
    task automatic step(string lab);
        #2;
        cmp_port(lab, int'(rd_a_idx), rd_a_value, rd_a_tag, rd_a_ready);
        cmp_port(lab, int'(rd_b_idx), rd_b_value, rd_b_tag, rd_b_ready);
        @(posedge clk);
        for (int i = 0; i < NREG; i++) begin
            bit m;
            m = ref_hit(i);
            if (m) ref_val[i] = int'(bc_data);
            if (iss_valid && int'(iss_dst) == i) ref_tag[i] = int'(iss_tag);
            else if (m)                          ref_tag[i] = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 1'b0;
        bc_valid  = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin ref_val[i] = 0; ref_tag[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: every register comes out of reset ready with value 0
        for (int i = 0; i < NREG; i += 2) begin
            rd_a_idx = IDX_W'(i); rd_b_idx = IDX_W'(i + 1);
            step("R7");
        end
        // R3: issue then resolve
        iss_valid = 1; iss_dst = 3; iss_tag = 4'd5; rd_a_idx = 3; step("");
        idle(); step("R2");
        bc_valid = 1; bc_tag = 4'd5; bc_data = 32'hCAFE_0001; step("R6");
        idle(); step("R3");
        // R4: retag while pending, stale result dropped
        iss_valid = 1; iss_dst = 3; iss_tag = 4'd2; step("");
        iss_tag = 4'd9; step("R2");
        idle(); bc_valid = 1; bc_tag = 4'd2; bc_data = 32'h1111_2222; step("R4");
        idle(); step("R4");
        bc_valid = 1; bc_tag = 4'd9; bc_data = 32'h3333_4444; step("");
        idle(); step("R3");
        // R8: invalid broadcast ignored
        iss_valid = 1; iss_dst = 7; iss_tag = 4'd6; rd_b_idx = 7; step("");
        idle(); bc_tag = 4'd6; bc_data = 32'hDEAD_BEEF; step("R8");
        step("R8");
        // R5: issue and matching broadcast in the same cycle
        iss_valid = 1; iss_dst = 7; iss_tag = 4'd11; bc_valid = 1; bc_tag = 4'd6; bc_data = 32'h0BAD_F00D;
        step("");
        idle(); step("R5");
        bc_valid = 1; bc_tag = 4'd11; bc_data = 32'h0000_7777; step("");
        idle(); step("R3");
        // random traffic compared every clock
        for (int n = 0; n < 4000; n++) begin
            rd_a_idx  = IDX_W'($urandom_range(NREG - 1, 0));
            rd_b_idx  = IDX_W'($urandom_range(NREG - 1, 0));
            iss_valid = ($urandom_range(99, 0) < 45);
            iss_dst   = IDX_W'($urandom_range(NREG - 1, 0));
            iss_tag   = TAG_W'($urandom_range(15, 1));
            bc_valid  = ($urandom_range(99, 0) < 70);
            bc_data   = DATA_W'($urandom);
            begin
                int pick;
                pick = $urandom_range(NREG - 1, 0);
                if ($urandom_range(99, 0) < 60 && ref_tag[pick] != 0) bc_tag = TAG_W'(ref_tag[pick]);
                else bc_tag = TAG_W'($urandom_range(15, 1));
                if ($urandom_range(99, 0) < 30 && ref_tag[pick] != 0) rd_a_idx = IDX_W'(pick);
            end
            step("");
        end
        idle();
        step("");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule